// File: doc/BRIEF.md
# Maintenance Address Window Translator

This block turns a memory-mapped access address into the routing fields that an outgoing maintenance transaction needs. It keeps a bank of programmable windows, sixteen by default. Each window has four 32-bit registers: a base, a mask with an enable flag, a 24-bit offset, and a control word. The control word carries the destination ID, hop count and priority. Software programs the windows through a simple register port with a fixed 16-byte stride per window.

A lookup request presents a 32-bit address. Every enabled window compares the address with its base over the bits its mask selects, and the lowest-numbered matching window is chosen. One cycle later the block returns the translated maintenance offset, the destination ID, the hop count, the priority and the window number. When no window matches, it raises a miss flag and returns zeros instead.

Top module: `mwt_translator`

## Requirements
- R1: Window n occupies byte addresses 0x10*n to 0x10*n+0xC, in this order of 32-bit registers: base (+0x0), mask (+0x4), offset (+0x8), control (+0xC). Writes and reads take effect only on those fields, and reserved bits read as zero:
  - base bits [2:0];
  - mask bits [1:0];
  - offset bits [31:24];
  - control bits [5:0].
- R2: After reset every register reads zero, except the control register, which reads 0x0000FF00 (hop count 0xFF). Every window is then disabled.
- R3: The control register holds the priority in bits [7:6]. Writing the value 3 stores 2, and a lookup result never carries priority 3.
- R4: The control register holds destination bits [23:16] and hop count bits [15:8]. Bits [31:24] hold the upper destination byte only when the WIDE_ID parameter is 1. With the default WIDE_ID=0 they read zero and rsp_dest[15:8] is always zero.
- R5: A window matches when its enable (mask bit 2) is set and, over address bits [31:3], (address AND mask) equals (base AND mask).
- R6: When several windows match, the result reports the lowest-numbered one.
- R7: When no window matches, rsp_miss is 1 and rsp_win, rsp_offset, rsp_dest, rsp_hops and rsp_prio are all zero.
- R8: rsp_offset is computed as follows, truncated to 24 bits, with bits [2:0] then forced to zero:
  - take the window offset;
  - add the address bits that the mask does not select.
- R9: A request accepted at one clock edge produces rsp_valid=1 after the next edge. Without a request, rsp_valid is 0 and every response field, including rsp_miss, is zero.
- R10: A lookup presented in the same cycle as a register write uses the configuration from before that write. A lookup in the following cycle uses the new one.
- R11: A disabled window never matches, even when its masked base equals the masked address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_WIN)+4 | Byte address for register read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after lk_req |
| rsp_miss | output | 1 | No enabled window matched |
| rsp_win | output | $clog2(NUM_WIN) | Index of the matching window |
| rsp_offset | output | 24 | Translated maintenance offset |
| rsp_dest | output | 16 | Destination ID (upper byte zero unless WIDE_ID) |
| rsp_hops | output | 8 | Hop count |
| rsp_prio | output | 2 | Priority, never 3 |

## Verification
The bench first goes after overlapping windows. A priority encoder that favours the highest index would report window 5 where window 2 is expected. It then targets a window whose compare succeeds while its enable is clear; a design that ignores the enable turns that miss into a hit. The offset sum is driven across its 24-bit boundary and the truncated, aligned value is checked, which catches a carry leaking into the result or unaligned low bits. The bench also writes priority 3 and watches it come back as 2. Finally, it issues a lookup in the same cycle as a write that disables its window, and expects the old window; a design that forwards the write would already report the next window.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

  localparam int REG_W = 32;
  localparam int OFF_W = 24;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_OFFS = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [28:0]      base;
    logic [28:0]      mask;
    logic             en;
    logic [OFF_W-1:0] off;
    logic [7:0]       dest_hi;
    logic [7:0]       dest;
    logic [7:0]       hops;
    logic [1:0]       prio;
  } win_cfg_t;

  localparam win_cfg_t CFG_RST = '{
    base: '0, mask: '0, en: 1'b0, off: '0,
    dest_hi: '0, dest: '0, hops: 8'hFF, prio: '0
  };

  // Illegal priority code 3 falls back to 2.
  function automatic logic [1:0] clamp_prio(input logic [1:0] p);
    return (p == 2'b11) ? 2'b10 : p;
  endfunction

  // Enabled window whose masked base equals the masked upper address.
  function automatic logic window_hit(input win_cfg_t c, input logic [28:0] a_hi);
    return c.en && (((a_hi ^ c.base) & c.mask) == 29'd0);
  endfunction

  // Offset plus unmasked address bits, 24-bit wrap, doubleword aligned.
  function automatic logic [OFF_W-1:0] xlate_offset(input logic [OFF_W-1:0] off,
                                                    input logic [28:0] mask,
                                                    input logic [REG_W-1:0] addr);
    logic [REG_W-1:0] keep;
    logic [OFF_W-1:0] sum;
    keep = addr & ~{mask, 3'b000};
    sum  = off + keep[OFF_W-1:0];
    return {sum[OFF_W-1:3], 3'b000};
  endfunction

  function automatic logic [REG_W-1:0] cfg_read(input win_cfg_t c, input reg_sel_e s);
    case (s)
      SEL_BASE: return {c.base, 3'b000};
      SEL_MASK: return {c.mask, c.en, 2'b00};
      SEL_OFFS: return {8'h00, c.off};
      default:  return {c.dest_hi, c.dest, c.hops, c.prio, 6'h00};
    endcase
  endfunction

endpackage

// File: rtl/mwt_regbank.sv
module mwt_regbank
  import mwt_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter bit WIDE_ID = 1'b0,
  parameter int IDX_W   = $clog2(NUM_WIN),
  parameter int RA_W    = IDX_W + 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [RA_W-1:0]           addr,
  input  logic [REG_W-1:0]          wdata,
  output logic [REG_W-1:0]          rdata,
  output win_cfg_t [NUM_WIN-1:0]    cfg
);

  logic [IDX_W-1:0]   acc_idx;
  reg_sel_e           acc_sel;
  logic [NUM_WIN-1:0] wr_hit;
  logic               unused_addr;

  assign acc_idx     = addr[RA_W-1:4];
  assign acc_sel     = reg_sel_e'(addr[3:2]);
  assign unused_addr = ^addr[1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    win_cfg_t r;

    assign wr_hit[w] = wr_en && (acc_idx == IDX_W'(w));
    assign cfg[w]    = r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= CFG_RST;
      end else if (wr_hit[w]) begin
        case (acc_sel)
          SEL_BASE: r.base <= wdata[31:3];
          SEL_MASK: begin
            r.mask <= wdata[31:3];
            r.en   <= wdata[2];
          end
          SEL_OFFS: r.off <= wdata[OFF_W-1:0];
          default: begin
            r.dest_hi <= WIDE_ID ? wdata[31:24] : 8'h00;
            r.dest    <= wdata[23:16];
            r.hops    <= wdata[15:8];
            r.prio    <= clamp_prio(wdata[7:6]);
          end
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(acc_idx) < NUM_WIN) rdata = cfg_read(cfg[acc_idx], acc_sel);
  end

endmodule

// File: rtl/mwt_match.sv
module mwt_match
  import mwt_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic [28:0]               addr_hi,
  input  win_cfg_t [NUM_WIN-1:0]    cfg,
  output logic [NUM_WIN-1:0]        hit_vec,
  output logic                      any_hit,
  output logic [IDX_W-1:0]          win_idx
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign hit_vec[w] = window_hit(cfg[w], addr_hi);
  end

  assign any_hit = |hit_vec;

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    win_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/mwt_respond.sv
module mwt_respond
  import mwt_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [REG_W-1:0] addr,
  input  logic             any_hit,
  input  logic [IDX_W-1:0] win_idx,
  input  win_cfg_t         sel_cfg,
  output logic             valid,
  output logic             miss,
  output logic [IDX_W-1:0] win,
  output logic [OFF_W-1:0] offset,
  output logic [15:0]      dest,
  output logic [7:0]       hops,
  output logic [1:0]       prio
);

  logic take;
  logic unused_cfg;

  assign take       = req && any_hit;
  assign unused_cfg = ^{sel_cfg.base, sel_cfg.en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      miss   <= 1'b0;
      win    <= '0;
      offset <= '0;
      dest   <= '0;
      hops   <= '0;
      prio   <= '0;
    end else begin
      valid <= req;
      miss  <= req && !any_hit;
      if (take) begin
        win    <= win_idx;
        offset <= xlate_offset(sel_cfg.off, sel_cfg.mask, addr);
        dest   <= {sel_cfg.dest_hi, sel_cfg.dest};
        hops   <= sel_cfg.hops;
        prio   <= sel_cfg.prio;
      end else begin
        win    <= '0;
        offset <= '0;
        dest   <= '0;
        hops   <= '0;
        prio   <= '0;
      end
    end
  end

endmodule

// File: rtl/mwt_translator.sv
module mwt_translator
  import mwt_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter bit WIDE_ID = 1'b0,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int RA_W   = IDX_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             lk_req,
  input  logic [31:0]      lk_addr,
  output logic             rsp_valid,
  output logic             rsp_miss,
  output logic [IDX_W-1:0] rsp_win,
  output logic [23:0]      rsp_offset,
  output logic [15:0]      rsp_dest,
  output logic [7:0]       rsp_hops,
  output logic [1:0]       rsp_prio
);

  win_cfg_t [NUM_WIN-1:0] cfg;
  logic [NUM_WIN-1:0]     match_vec;
  logic                   any_hit;
  logic [IDX_W-1:0]       sel_idx;
  win_cfg_t               sel_cfg;

  mwt_regbank #(.NUM_WIN(NUM_WIN), .WIDE_ID(WIDE_ID), .IDX_W(IDX_W), .RA_W(RA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  mwt_match #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_match (
    .addr_hi (lk_addr[31:3]),
    .cfg     (cfg),
    .hit_vec (match_vec),
    .any_hit (any_hit),
    .win_idx (sel_idx)
  );

  assign sel_cfg = cfg[sel_idx];

  mwt_respond #(.IDX_W(IDX_W)) u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (lk_req),
    .addr    (lk_addr),
    .any_hit (any_hit),
    .win_idx (sel_idx),
    .sel_cfg (sel_cfg),
    .valid   (rsp_valid),
    .miss    (rsp_miss),
    .win     (rsp_win),
    .offset  (rsp_offset),
    .dest    (rsp_dest),
    .hops    (rsp_hops),
    .prio    (rsp_prio)
  );

endmodule

// File: rtl/mwt_checker.sv
module mwt_checker #(
  parameter int NUM_WIN = 16,
  parameter int IDX_W   = 4,
  parameter bit WIDE_ID = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic [NUM_WIN-1:0] match_vec,
  input logic               any_hit,
  input logic               rsp_valid,
  input logic               rsp_miss,
  input logic [IDX_W-1:0]   rsp_win,
  input logic [23:0]        rsp_offset,
  input logic [15:0]        rsp_dest,
  input logic [7:0]         rsp_hops,
  input logic [1:0]         rsp_prio
);

  logic [NUM_WIN-1:0] prev_vec;
  logic [NUM_WIN-1:0] below;
  logic               fields_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_vec <= '0;
    else        prev_vec <= match_vec;
  end

  always_comb begin
    for (int i = 0; i < NUM_WIN; i++) below[i] = (i < int'(rsp_win));
  end

  assign fields_zero = (rsp_win == '0) && (rsp_offset == '0) && (rsp_dest == '0) &&
                       (rsp_hops == '0) && (rsp_prio == '0);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);                                         // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);                                       // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_miss && fields_zero));                    // R9
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> fields_zero);                      // R7
  AST_MISS_TRACKS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (rsp_miss == !$past(any_hit)));                     // R7
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss) |-> (prev_vec[rsp_win] && ((prev_vec & below) == '0))); // R6
  AST_PRIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_prio != 2'b11));                            // R3
  AST_OFFSET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_offset[2:0] == 3'b000));                    // R8
  AST_NARROW_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (!WIDE_ID) |-> (rsp_dest[15:8] == 8'h00));                     // R4

endmodule

bind mwt_translator mwt_checker #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .WIDE_ID(WIDE_ID)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_req     (lk_req),
  .match_vec  (match_vec),
  .any_hit    (any_hit),
  .rsp_valid  (rsp_valid),
  .rsp_miss   (rsp_miss),
  .rsp_win    (rsp_win),
  .rsp_offset (rsp_offset),
  .rsp_dest   (rsp_dest),
  .rsp_hops   (rsp_hops),
  .rsp_prio   (rsp_prio)
);

// File: tb/tb_mwt_translator.sv
`timescale 1ns/1ps
module tb_mwt_translator;

  localparam int  NW   = 16;
  localparam time HALF = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        rsp_valid, rsp_miss;
  logic [3:0]  rsp_win;
  logic [23:0] rsp_offset;
  logic [15:0] rsp_dest;
  logic [7:0]  rsp_hops;
  logic [1:0]  rsp_prio;

  always #HALF clk = ~clk;

  mwt_translator dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
    .rsp_offset(rsp_offset), .rsp_dest(rsp_dest), .rsp_hops(rsp_hops), .rsp_prio(rsp_prio)
  );

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  // Bench-side model of the programmed windows.
  logic [31:0] m_base [NW];
  logic [31:0] m_mask [NW];
  bit          m_en   [NW];
  logic [23:0] m_off  [NW];
  logic [7:0]  m_dest [NW];
  logic [7:0]  m_hops [NW];
  logic [1:0]  m_prio [NW];

  typedef struct {
    string       tag;
    logic [54:0] v;   // {miss, win, offset, dest, hops, prio}
  } exp_t;
  exp_t sb[$];

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int w = 0; w < NW; w++) begin
      m_base[w] = '0; m_mask[w] = '0; m_en[w] = 1'b0; m_off[w] = '0;
      m_dest[w] = '0; m_hops[w] = 8'hFF; m_prio[w] = '0;
    end
  endfunction

  function automatic void model_write(input int w, input int s, input logic [31:0] d);
    case (s)
      0: m_base[w] = d & 32'hFFFF_FFF8;
      1: begin m_mask[w] = d & 32'hFFFF_FFF8; m_en[w] = d[2]; end
      2: m_off[w] = d[23:0];
      default: begin
        m_dest[w] = d[23:16];
        m_hops[w] = d[15:8];
        m_prio[w] = (d[7:6] == 2'd3) ? 2'd2 : d[7:6];
      end
    endcase
  endfunction

  function automatic logic [31:0] model_read(input int w, input int s);
    case (s)
      0: return m_base[w];
      1: return m_mask[w] | (m_en[w] ? 32'h4 : 32'h0);
      2: return {8'h00, m_off[w]};
      default: return {8'h00, m_dest[w], m_hops[w], m_prio[w], 6'h00};
    endcase
  endfunction

  function automatic logic [54:0] predict(input logic [31:0] a);
    logic [54:0] r;
    logic [31:0] sum;
    r = {1'b1, 54'd0};
    for (int w = NW - 1; w >= 0; w--) begin
      if (m_en[w] && ((a & m_mask[w]) == (m_base[w] & m_mask[w]))) begin
        sum = {8'h00, m_off[w]} + (a & ~m_mask[w]);
        r = {1'b0, 4'(w), sum[23:3], 3'b000, 8'h00, m_dest[w], m_hops[w], m_prio[w]};
      end
    end
    return r;
  endfunction

  task automatic do_write(input int w, input int s, input logic [31:0] d);
    @(negedge clk);
    lk_req = 1'b0; reg_wr = 1'b1;
    reg_addr = {4'(w), 2'(s), 2'b00}; reg_wdata = d;
    model_write(w, s, d);
  endtask

  task automatic do_look(input logic [31:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    reg_wr = 1'b0; lk_req = 1'b1; lk_addr = a;
    e.tag = tag; e.v = predict(a);
    sb.push_back(e);
  endtask

  // Lookup and write in the same cycle: the lookup sees the old setup (R10).
  task automatic write_and_look(input int w, input int s, input logic [31:0] d,
                                input logic [31:0] a);
    exp_t e;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {4'(w), 2'(s), 2'b00}; reg_wdata = d;
    lk_req = 1'b1; lk_addr = a;
    e.tag = "R10"; e.v = predict(a);
    sb.push_back(e);
    model_write(w, s, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_wr = 1'b0; lk_req = 1'b0;
    end
  endtask

  task automatic read_check(input int w, input int s, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; lk_req = 1'b0;
    reg_addr = {4'(w), 2'(s), 2'b00};
    #1;
    check(tag, $sformatf("readback w%0d r%0d", w, s), 64'(reg_rdata), 64'(model_read(w, s)));
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  always @(negedge clk) begin
    if (mon_on) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check("R9", "unexpected rsp_valid", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, "lookup result",
                64'({rsp_miss, rsp_win, rsp_offset, rsp_dest, rsp_hops, rsp_prio}), 64'(e.v));
        end
      end else begin
        check("R9", "idle outputs",
              64'({rsp_miss, rsp_win, rsp_offset, rsp_dest, rsp_hops, rsp_prio}), 64'd0);
      end
    end
  end

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R2: reset values.
    for (int w = 0; w < NW; w += 5)
      for (int s = 0; s < 4; s++) read_check(w, s, "R2");
    do_look(32'h4000_0000, "R7");
    do_look(32'h0000_0000, "R2");
    idle(2);

    // R1, R3, R4: reserved bits, clamp, narrow destination.
    for (int s = 0; s < 4; s++) do_write(0, s, 32'hFFFF_FFFF);
    idle(1);
    for (int s = 0; s < 4; s++) read_check(0, s, "R1");
    read_check(0, 3, "R3");
    @(negedge clk); reg_addr = 8'h0C; #1;
    check("R4", "upper destination byte", 64'(reg_rdata[31:24]), 64'd0);
    check("R3", "stored priority", 64'(reg_rdata[7:6]), 64'd2);
    do_write(0, 1, 32'h0);
    do_write(0, 0, 32'h0);
    do_write(0, 2, 32'h0);
    do_write(0, 3, 32'h0000_FF00);

    // Window setup.
    do_write(2, 0, 32'h4000_0000); do_write(2, 1, 32'hF000_0004);
    do_write(2, 2, 32'h10_0000);   do_write(2, 3, 32'h0012_0340);
    do_write(5, 0, 32'h4000_0000); do_write(5, 1, 32'hFF00_0004);
    do_write(5, 2, 32'h00_2000);   do_write(5, 3, 32'h0055_0980);
    do_write(7, 0, 32'h8000_0000); do_write(7, 1, 32'hFFFF_0000);
    do_write(7, 2, 32'h00_0400);   do_write(7, 3, 32'h0077_0100);
    do_write(9, 0, 32'h9000_0000); do_write(9, 1, 32'hFFF0_0004);
    do_write(9, 2, 32'hFF_FFF0);   do_write(9, 3, 32'h0099_0200);
    idle(1);

    // Back-to-back lookups.
    do_look(32'h4000_1238, "R6");
    do_look(32'h4A00_0010, "R5");
    do_look(32'h8000_1234, "R11");
    do_look(32'h9000_0ABC, "R8");
    do_look(32'h9010_0000, "R7");
    do_look(32'h4000_0007, "R8");
    idle(2);

    do_write(7, 1, 32'hFFFF_0004);
    do_look(32'h8000_FFFF, "R5");
    idle(1);

    // R10: disable window 2 while looking it up.
    write_and_look(2, 1, 32'hF000_0000, 32'h4000_0100);
    do_look(32'h4000_0100, "R10");
    do_look(32'h4800_0000, "R7");
    idle(1);

    // R3: priority 3 written, 2 reported.
    do_write(5, 3, 32'h00AB_07C0);
    do_look(32'h4000_0000, "R3");
    idle(1);
    read_check(5, 3, "R3");

    // Mixed traffic.
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom;
      if (r[1:0] == 2'd0) begin
        logic [31:0] d;
        d = $urandom;
        if (r[4:3] == 2'd1) d = d | 32'h4;
        do_write(int'(r[11:8]), int'(r[6:5]), d);
      end else begin
        logic [31:0] a;
        a = $urandom;
        case (r[3:2])
          2'd0: a[31:28] = 4'h4;
          2'd1: a[31:24] = 8'h80;
          2'd2: a[31:20] = 12'h900;
          default: ;
        endcase
        do_look(a, "R5");
      end
    end
    idle(4);
    check("R9", "scoreboard drained", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule